// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block sits between a processor's byte-wide load/store port and a slower block-wide memory port. Each request address is cut into three fields: the low two bits pick a byte inside a four-byte block, the middle bits select one set, and the upper bits form the tag. Each set holds two lines, and a block may live in either of them. When the requested block is present, the access completes at once. Otherwise the controller fetches the block, installs it, and then serves the request from the cache.

Stores stay in the cache and mark the line as modified. A modified line goes back to memory only when it is chosen for replacement. Lines in a full set are replaced in the order they arrived, and hits do not change that order. A snoop input reports blocks that another bus master has written, and any copy of such a block held here is dropped.

The address width is 24 bits. The index width is a parameter: it defaults to 6 bits (64 sets), and a 13-bit index with a 9-bit tag is just a parameter choice. The controller has three states:
- IDLE: lookup and hit service.
- EVICT: writes back a modified victim.
- REFILL: reads the block and installs it.

The transitions are:
- IDLE→EVICT on a miss whose victim is modified.
- IDLE→REFILL on a miss whose victim is clean or empty.
- EVICT→REFILL when the write-back handshake completes.
- REFILL→IDLE when the read handshake completes.

Top module: `cache_wb2`

## Requirements
- R1: Address bits [1:0] select the byte, bits [7:2] the set and bits [23:8] the tag (default widths). Byte k of a block travels on data bits [8k+7:8k]. mem_addr always carries a block address with its two low bits zero.
- R2: After reset every line is invalid and every set's replacement pointer is 0, and cpu_ready and mem_valid are low.
- R3: A request whose tag matches a valid line in its set is a hit. cpu_ready rises in the same cycle, a read returns the addressed byte on cpu_rdata, and a write replaces only that byte. No memory transfer takes place, and at most one way matches.
- R4: On a read miss cpu_ready stays low while exactly one block is read from memory and installed. The request then completes from the cache with the fetched byte.
- R5: A miss fills an invalid way when one exists, and way 0 when both ways are invalid.
- R6: When both ways are valid, the victim is the line installed earlier. Hits do not change the order, so a recently read line can still be evicted.
- R7: A write marks the line modified and is not sent to memory. Evicting a modified line writes its block (with the stored bytes) to memory before the refill read is issued. Evicting an unmodified line issues no memory write.
- R8: A store miss fetches the block, installs it with the stored byte merged in, and marks it modified.
- R9: A memory request holds mem_valid, mem_addr and mem_we stable until mem_ready. A transfer happens in the cycle both are high.
- R10: A snoop_valid pulse whose address falls in a cached block invalidates that line, so the next access misses and reads the block again. A snoop of a block that is not cached changes nothing, and a following access to a cached block still hits.
- R11: A snoop of the block being fetched, arriving while the refill is outstanding, leaves the installed line invalid, so the held request fetches the block a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 8 | Load byte, valid with cpu_ready |
| mem_valid | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 24 | Block-aligned memory address |
| mem_wdata | output | 32 | Write-back block |
| mem_ready | input | 1 | Memory accepts or returns the block this cycle |
| mem_rdata | input | 32 | Read block, valid with mem_ready |
| snoop_valid | input | 1 | Another master wrote the block at snoop_addr |
| snoop_addr | input | 24 | Address written by the other master |

## Verification
The bench drives one set through a sequence in which a recently read line must still be evicted. A design that replaces the least recently used line instead of the oldest one would keep the wrong tag, and the bench would see a miss where it expects a hit. It counts memory reads and writes per access, so a design that writes back a clean victim, skips the write-back of a modified one, or fills the wrong way shows an off-by-one in those counts. It checks that a byte stored before an eviction comes back after a refill. The snoop cases invalidate a present line, snoop an absent block, and snoop a block in the middle of its own refill; a design that installs the line despite the snoop returns stale data and makes one memory read too few.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } cstate_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int TAG_W = 16,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic [1:0]       way_hit,
    output logic             hit,
    output logic             hit_way,
    output logic             vict_way,
    output logic             vict_dirty,
    output logic [TAG_W-1:0] vict_tag,
    input  logic             set_dirty,
    input  logic             inst_en,
    input  logic             inst_way,
    input  logic [IDX_W-1:0] inst_idx,
    input  logic [TAG_W-1:0] inst_tag,
    input  logic             inst_valid,
    input  logic             inst_dirty,
    input  logic             snp_en,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag
);
    localparam int SETS = 1 << IDX_W;

    logic [1:0]            vld_at;
    logic [1:0]            dty_at;
    logic [1:0][TAG_W-1:0] tag_at;
    logic [SETS-1:0]       fifo_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]  vld;
        logic [SETS-1:0]  dty;
        logic [TAG_W-1:0] tags [SETS];
        logic             inst_here;
        logic             snp_kill;

        assign inst_here = inst_en && (inst_way == 1'(w));
        assign snp_kill  = snp_en && vld[snp_idx] && (tags[snp_idx] == snp_tag)
                           && !(inst_here && (inst_idx == snp_idx));

        always_ff @(posedge clk) begin
            if (inst_here) tags[inst_idx] <= inst_tag;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= '0;
                dty <= '0;
            end else begin
                if (set_dirty && way_hit[w]) dty[look_idx] <= 1'b1;
                if (inst_here) begin
                    vld[inst_idx] <= inst_valid;
                    dty[inst_idx] <= inst_valid && inst_dirty;
                end
                if (snp_kill) begin
                    vld[snp_idx] <= 1'b0;
                    dty[snp_idx] <= 1'b0;
                end
            end
        end

        assign vld_at[w]  = vld[look_idx];
        assign dty_at[w]  = dty[look_idx];
        assign tag_at[w]  = tags[look_idx];
        assign way_hit[w] = vld_at[w] && (tag_at[w] == look_tag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       fifo_q <= '0;
        else if (inst_en) fifo_q[inst_idx] <= ~inst_way;
    end

    assign hit        = |way_hit;
    assign hit_way    = way_hit[1];
    assign vict_way   = !vld_at[0] ? 1'b0 : (!vld_at[1] ? 1'b1 : fifo_q[look_idx]);
    assign vict_dirty = vld_at[vict_way] && dty_at[vict_way];
    assign vict_tag   = tag_at[vict_way];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int IDX_W = 6,
    parameter int BLK_W = 32
) (
    input  logic                 clk,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [1:0][BLK_W-1:0] rd_blk,
    input  logic                 wr_en,
    input  logic                 wr_way,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [BLK_W-1:0]     wr_blk
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [BLK_W-1:0] mem [SETS];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(w))) mem[wr_idx] <= wr_blk;
        end
        assign rd_blk[w] = mem[rd_idx];
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 2,
    parameter int TAG_W  = ADDR_W - IDX_W - OFF_W,
    parameter int BLK_W  = 8 << OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [7:0]            cpu_wdata,
    output logic                  cpu_ready,
    output logic [7:0]            cpu_rdata,
    output logic                  mem_valid,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [BLK_W-1:0]      mem_wdata,
    input  logic                  mem_ready,
    input  logic [BLK_W-1:0]      mem_rdata,
    input  logic                  snp_blk_hit_req,
    output logic [ADDR_W-OFF_W-1:0] miss_blk,
    output logic [IDX_W-1:0]      look_idx,
    output logic [TAG_W-1:0]      look_tag,
    input  logic                  hit,
    input  logic                  hit_way,
    input  logic                  vict_way,
    input  logic                  vict_dirty,
    input  logic [TAG_W-1:0]      vict_tag,
    output logic                  set_dirty,
    output logic                  inst_en,
    output logic                  inst_way,
    output logic [IDX_W-1:0]      inst_idx,
    output logic [TAG_W-1:0]      inst_tag,
    output logic                  inst_valid,
    output logic                  inst_dirty,
    input  logic [1:0][BLK_W-1:0] rd_blk,
    output logic                  wr_en,
    output logic                  wr_way,
    output logic [IDX_W-1:0]      wr_idx,
    output logic [BLK_W-1:0]      wr_blk,
    output cstate_e               state
);
    cstate_e            state_q, state_d;
    logic [ADDR_W-1:0]  miss_addr_q;
    logic               miss_we_q;
    logic [7:0]         miss_wdata_q;
    logic               vict_q;
    logic [TAG_W-1:0]   vict_tag_q;
    logic               cancel_q;

    logic [IDX_W-1:0]   cpu_idx, miss_idx;
    logic [OFF_W-1:0]   cpu_off;
    logic               miss_now;

    function automatic logic [BLK_W-1:0] merge_byte(input logic [BLK_W-1:0] blk,
                                                     input logic [OFF_W-1:0] off,
                                                     input logic [7:0] b);
        logic [BLK_W-1:0] r;
        r = blk;
        r[{off, 3'b000} +: 8] = b;
        return r;
    endfunction

    assign cpu_idx   = cpu_addr[OFF_W +: IDX_W];
    assign cpu_off   = cpu_addr[OFF_W-1:0];
    assign miss_idx  = miss_addr_q[OFF_W +: IDX_W];
    assign miss_blk  = miss_addr_q[ADDR_W-1:OFF_W];
    assign look_idx  = (state_q == ST_IDLE) ? cpu_idx : miss_idx;
    assign look_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_rdata = rd_blk[hit_way][{cpu_off, 3'b000} +: 8];
    assign miss_now  = (state_q == ST_IDLE) && cpu_req && !hit;
    assign state     = state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            miss_addr_q  <= '0;
            miss_we_q    <= 1'b0;
            miss_wdata_q <= '0;
            vict_q       <= 1'b0;
            vict_tag_q   <= '0;
            cancel_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (miss_now) begin
                miss_addr_q  <= cpu_addr;
                miss_we_q    <= cpu_we;
                miss_wdata_q <= cpu_wdata;
                vict_q       <= vict_way;
                vict_tag_q   <= vict_tag;
                cancel_q     <= 1'b0;
            end else if (snp_blk_hit_req && (state_q != ST_IDLE)) begin
                cancel_q     <= 1'b1;
            end
        end
    end

    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        mem_valid  = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {miss_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wdata  = rd_blk[vict_q];
        set_dirty  = 1'b0;
        inst_en    = 1'b0;
        inst_way   = vict_q;
        inst_idx   = miss_idx;
        inst_tag   = miss_addr_q[ADDR_W-1 -: TAG_W];
        inst_valid = !(cancel_q || snp_blk_hit_req);
        inst_dirty = miss_we_q;
        wr_en      = 1'b0;
        wr_way     = hit_way;
        wr_idx     = cpu_idx;
        wr_blk     = merge_byte(rd_blk[hit_way], cpu_off, cpu_wdata);
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && hit) begin
                    cpu_ready = 1'b1;
                    wr_en     = cpu_we;
                    set_dirty = cpu_we;
                end else if (cpu_req) begin
                    state_d = vict_dirty ? ST_EVICT : ST_REFILL;
                end
            end
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {vict_tag_q, miss_idx, {OFF_W{1'b0}}};
                if (mem_ready) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    inst_en = 1'b1;
                    wr_en   = 1'b1;
                    wr_way  = vict_q;
                    wr_idx  = miss_idx;
                    wr_blk  = miss_we_q ? merge_byte(mem_rdata, miss_addr_q[OFF_W-1:0], miss_wdata_q)
                                        : mem_rdata;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/cache_wb2.sv
module cache_wb2
    import cache_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ready,
    output logic [7:0]        cpu_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [(8<<OFF_W)-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [(8<<OFF_W)-1:0] mem_rdata,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W = 8 << OFF_W;

    logic [IDX_W-1:0]      look_idx, inst_idx, wr_idx;
    logic [TAG_W-1:0]      look_tag, vict_tag, inst_tag;
    logic [1:0]            way_hit;
    logic                  hit, hit_way, vict_way, vict_dirty, set_dirty;
    logic                  inst_en, inst_way, inst_valid, inst_dirty;
    logic                  wr_en, wr_way, snp_blk_hit_req;
    logic [1:0][BLK_W-1:0] rd_blk;
    logic [BLK_W-1:0]      wr_blk;
    logic [ADDR_W-OFF_W-1:0] miss_blk;
    cstate_e               state;

    assign snp_blk_hit_req = snoop_valid && (snoop_addr[ADDR_W-1:OFF_W] == miss_blk);

    cache_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .look_idx(look_idx), .look_tag(look_tag),
        .way_hit(way_hit), .hit(hit), .hit_way(hit_way),
        .vict_way(vict_way), .vict_dirty(vict_dirty), .vict_tag(vict_tag),
        .set_dirty(set_dirty),
        .inst_en(inst_en), .inst_way(inst_way), .inst_idx(inst_idx),
        .inst_tag(inst_tag), .inst_valid(inst_valid), .inst_dirty(inst_dirty),
        .snp_en(snoop_valid),
        .snp_idx(snoop_addr[OFF_W +: IDX_W]),
        .snp_tag(snoop_addr[ADDR_W-1 -: TAG_W])
    );

    cache_data_store #(.IDX_W(IDX_W), .BLK_W(BLK_W)) u_data (
        .clk(clk), .rd_idx(look_idx), .rd_blk(rd_blk),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_blk(wr_blk)
    );

    cache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
                 .TAG_W(TAG_W), .BLK_W(BLK_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .snp_blk_hit_req(snp_blk_hit_req), .miss_blk(miss_blk),
        .look_idx(look_idx), .look_tag(look_tag),
        .hit(hit), .hit_way(hit_way), .vict_way(vict_way),
        .vict_dirty(vict_dirty), .vict_tag(vict_tag),
        .set_dirty(set_dirty),
        .inst_en(inst_en), .inst_way(inst_way), .inst_idx(inst_idx),
        .inst_tag(inst_tag), .inst_valid(inst_valid), .inst_dirty(inst_dirty),
        .rd_blk(rd_blk), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_blk(wr_blk),
        .state(state)
    );
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_valid,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        way_hit
);
    AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));                                                   // R3
    AST_READY_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (cpu_req && !mem_valid));                               // R4
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R9
    AST_BLK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0));                           // R1
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && mem_ready) |=> (mem_valid && !mem_we));       // R7
endmodule

bind cache_wb2 cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .way_hit(way_hit)
);

// File: tb/tb_cache_wb2.sv
module tb_cache_wb2;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        mem_valid, mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        snoop_valid = 1'b0;
    logic [23:0] snoop_addr = '0;

    always #5 clk = ~clk;

    cache_wb2 dut (.*);

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, wr_cnt = 0, mem_lat = 2, lat_cnt = 0;
    logic [23:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    logic [31:0] mem_blk [int];
    logic [7:0]  ref_byte [int];

    function automatic logic [23:0] mk(input int t, input int i, input int o);
        return {16'(t), 6'(i), 2'(o)};
    endfunction

    function automatic logic [7:0] init_byte(input logic [23:0] a);
        return a[9:2] ^ {a[1:0], 6'h15} ^ a[17:10];
    endfunction

    function automatic logic [31:0] mem_read(input logic [23:0] a);
        logic [31:0] b;
        if (mem_blk.exists(int'(a[23:2]))) return mem_blk[int'(a[23:2])];
        for (int k = 0; k < 4; k++) b[8*k +: 8] = init_byte({a[23:2], 2'(k)});
        return b;
    endfunction

    function automatic logic [7:0] ref_rd(input logic [23:0] a);
        if (ref_byte.exists(int'(a))) return ref_byte[int'(a)];
        return init_byte(a);
    endfunction

    // memory model: registered ready after mem_lat cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            lat_cnt = 0;
        end else if (mem_valid && mem_ready) begin
            if (mem_we) begin
                mem_blk[int'(mem_addr[23:2])] = mem_wdata;
                last_wr_addr = mem_addr;
                last_wr_data = mem_wdata;
                wr_cnt++;
            end else begin
                rd_cnt++;
            end
            mem_ready <= 1'b0;
            lat_cnt = 0;
        end else if (mem_valid) begin
            if (lat_cnt >= mem_lat) begin
                mem_ready <= 1'b1;
                mem_rdata <= mem_read(mem_addr);
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [23:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int waits);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        waits = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            waits++;
        end
        rd = cpu_rdata;
        if (we) ref_byte[int'(a)] = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    // another master writes a whole block and announces it
    task automatic other_write(input logic [23:0] a, input logic [31:0] blk);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = a;
        mem_blk[int'(a[23:2])] = blk;
        for (int k = 0; k < 4; k++) ref_byte[int'({a[23:2], 2'(k)})] = blk[8*k +: 8];
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    typedef struct packed {
        logic       we;
        logic [15:0] tag;
        logic [5:0] idx;
        logic [1:0] off;
        logic [7:0] wd;
        logic [3:0] d_rd;
        logic [3:0] d_wr;
    } vec_t;

    // R4 R5 R6 R7 R8: expected memory reads/writes per access
    localparam vec_t VEC [13] = '{
        '{1'b0, 16'd1, 6'd5, 2'd0, 8'h00, 4'd1, 4'd0},  // miss, fills way 0 (R5)
        '{1'b0, 16'd1, 6'd5, 2'd3, 8'h00, 4'd0, 4'd0},  // hit (R3)
        '{1'b1, 16'd1, 6'd5, 2'd1, 8'h77, 4'd0, 4'd0},  // store hit, dirty (R7)
        '{1'b0, 16'd2, 6'd5, 2'd0, 8'h00, 4'd1, 4'd0},  // miss, fills way 1 (R5)
        '{1'b0, 16'd1, 6'd5, 2'd1, 8'h00, 4'd0, 4'd0},  // hit, order unchanged (R6)
        '{1'b0, 16'd3, 6'd5, 2'd2, 8'h00, 4'd1, 4'd1},  // evicts oldest dirty tag 1 (R6 R7)
        '{1'b0, 16'd2, 6'd5, 2'd1, 8'h00, 4'd0, 4'd0},  // tag 2 kept (R6)
        '{1'b0, 16'd1, 6'd5, 2'd1, 8'h00, 4'd1, 4'd0},  // clean victim, no write (R7)
        '{1'b1, 16'd4, 6'd9, 2'd2, 8'hC3, 4'd1, 4'd0},  // store miss allocates (R8)
        '{1'b0, 16'd4, 6'd9, 2'd2, 8'h00, 4'd0, 4'd0},
        '{1'b0, 16'd5, 6'd9, 2'd0, 8'h00, 4'd1, 4'd0},
        '{1'b0, 16'd6, 6'd9, 2'd0, 8'h00, 4'd1, 4'd1},  // allocated line is dirty (R8)
        '{1'b0, 16'd4, 6'd9, 2'd2, 8'h00, 4'd1, 4'd0}
    };

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int waits, r0, w0;
        repeat (3) @(negedge clk);
        // R2: reset state at the ports
        check(cpu_ready == 1'b0, "R2 ready", int'(cpu_ready), 0);
        check(mem_valid == 1'b0, "R2 mem_valid", int'(mem_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_valid == 1'b0, "R2 idle after reset", int'(mem_valid), 0);

        for (int v = 0; v < 13; v++) begin
            logic [23:0] a;
            logic [7:0]  exp;
            a  = {VEC[v].tag, VEC[v].idx, VEC[v].off};
            r0 = rd_cnt; w0 = wr_cnt;
            exp = ref_rd(a);
            access(VEC[v].we, a, VEC[v].wd, rd, waits);
            if (!VEC[v].we) check(rd == exp, "R3/R4 read data", int'(rd), int'(exp));
            check(rd_cnt - r0 == int'(VEC[v].d_rd), "R4 memory reads", rd_cnt - r0, int'(VEC[v].d_rd));
            check(wr_cnt - w0 == int'(VEC[v].d_wr), "R7 memory writes", wr_cnt - w0, int'(VEC[v].d_wr));
            check((waits > 0) == (VEC[v].d_rd != 0), "R4 ready low on miss", waits, int'(VEC[v].d_rd));
            if (v == 5) begin
                // R7: write-back carries the stored byte to the victim block address
                check(last_wr_addr == mk(1, 5, 0), "R7 write-back address",
                      int'(last_wr_addr), int'(mk(1, 5, 0)));
                check(last_wr_data[15:8] == 8'h77, "R7 write-back byte",
                      int'(last_wr_data[15:8]), 32'h77);
            end
        end

        // R9: latency stretches the miss, handshake honoured
        mem_lat = 5;
        r0 = rd_cnt;
        access(1'b0, mk(20, 30, 0), 8'h00, rd, waits);
        check(waits >= 6, "R9 waits for mem_ready", waits, 6);
        check(rd == ref_rd(mk(20, 30, 0)), "R1 byte 0 lane", int'(rd), int'(ref_rd(mk(20, 30, 0))));
        access(1'b0, mk(20, 30, 3), 8'h00, rd, waits);
        check(rd == ref_rd(mk(20, 30, 3)), "R1 byte 3 lane", int'(rd), int'(ref_rd(mk(20, 30, 3))));
        mem_lat = 2;

        // R10: snoop invalidates a present line
        access(1'b0, mk(7, 20, 0), 8'h00, rd, waits);
        other_write(mk(7, 20, 2), 32'hDEADBEEF);
        r0 = rd_cnt;
        access(1'b0, mk(7, 20, 1), 8'h00, rd, waits);
        check(rd == 8'hBE, "R10 new data after snoop", int'(rd), 32'hBE);
        check(rd_cnt - r0 == 1, "R10 refetch after snoop", rd_cnt - r0, 1);

        // R10: snoop of an absent block leaves the cached line alone
        other_write(mk(8, 20, 0), 32'h01020304);
        r0 = rd_cnt;
        access(1'b0, mk(7, 20, 3), 8'h00, rd, waits);
        check(rd_cnt - r0 == 0, "R10 absent snoop no effect", rd_cnt - r0, 0);
        check(rd == 8'hDE, "R10 data kept", int'(rd), 32'hDE);

        // R11: snoop during refill cancels the install
        mem_lat = 6;
        r0 = rd_cnt;
        fork
            access(1'b0, mk(9, 21, 0), 8'h00, rd, waits);
            begin
                repeat (3) @(negedge clk);
                snoop_valid = 1'b1; snoop_addr = mk(9, 21, 1);
                mem_blk[int'(mk(9, 21, 0) >> 2)] = 32'h11223344;
                for (int k = 0; k < 4; k++) ref_byte[int'(mk(9, 21, k))] = 8'(32'h11223344 >> (8 * k));
                @(negedge clk);
                snoop_valid = 1'b0;
            end
        join
        check(rd_cnt - r0 == 2, "R11 second fetch", rd_cnt - r0, 2);
        check(rd == 8'h44, "R11 fresh data", int'(rd), 32'h44);
        mem_lat = 2;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule